// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer between two unrelated clock domains. Words enter on the write clock and leave on the read clock. Each pointer crosses into the other domain as a Gray code through two flip-flops. Five active-low status outputs describe the fill level: empty, full, half-full, almost-empty and almost-full. The two almost thresholds are programmable.

A load control changes what the data ports do. While it is low, a write stores its data word into a pair of threshold registers instead of the buffer, and a read returns those registers on the output bus instead of removing a word. Successive load accesses on each port alternate between the almost-empty threshold and the almost-full threshold, always starting with the almost-empty one.

A mode input chooses how the almost flags are produced. When it is high they are computed combinationally from the live pointers of both domains. When it is low they are registered in their own clock domain. A replay strobe rewinds the read side to storage location zero, so the data written since reset can be read out again. An output enable places the data bus in high impedance.

Top module: `pfifo_dual_clock`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_n` low, `ld_n` high and `full_n` high, the 18-bit `din` word is stored at the tail of the buffer.
- R2: A write attempted while `full_n` is low has no effect: no word is stored and no stored word is lost.
- R3: On a rising `rd_clk` edge with `rd_n` low, `ld_n` high, `replay` low and `empty_n` high, the oldest word is removed and appears on `dout` after that edge, in write order. A read attempted while `empty_n` is low leaves `dout` and the contents unchanged.
- R4: `empty_n` is registered on `rd_clk` and is low when no word is held. `full_n` is registered on `wr_clk` and is low when DEPTH (default 64) words are held. The count never exceeds DEPTH.
- R5: With `ld_n` low, each `wr_n`-low write edge stores `din[6:0]` (width log2(DEPTH)+1) into a threshold register instead of the buffer. The first load after reset goes to the almost-empty threshold, the next to the almost-full threshold, and so on, alternating.
- R6: With `ld_n` low, each `rd_n`-low read edge places a threshold, zero-extended, on `dout` without removing a word. The first readback goes to almost-empty, then almost-full, alternating.
- R7: `aempty_n` is low when the count is at or below the almost-empty threshold. `afull_n` is low when DEPTH minus the count is at or below the almost-full threshold.
- R8: With `async_mode` high, the almost flags follow pointer changes immediately after the causing edge. With it low, `aempty_n` is registered on `rd_clk` and `afull_n` on `wr_clk`, so each lags by the pointer synchronizer.
- R9: `half_n` is registered on `wr_clk` and is low exactly when the count exceeds DEPTH/2.
- R10: A read-clock edge with `replay` high sets the read pointer to location zero, taking priority over a read. Provided no more than DEPTH words were written since reset, all of them are then read again in order.
- R11: `dout` is driven while `oe_n` is low and is high impedance while `oe_n` is high.
- R12: While `rst_n` is low the buffer is empty, both thresholds are 7, both access selectors point to almost-empty and the output register is zero. Reset asserts asynchronously and releases synchronously in each domain.
- R13: Each pointer crosses domains as a Gray code through a two-stage synchronizer. The write pointer's Gray code changes by at most one bit per write-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 18 | Write data, or threshold value during load |
| wr_n | input | 1 | Active-low write enable |
| rd_n | input | 1 | Active-low read enable |
| ld_n | input | 1 | Active-low threshold load/readback select |
| replay | input | 1 | Rewind read pointer to location zero (read clock) |
| oe_n | input | 1 | Active-low output enable for `dout` |
| async_mode | input | 1 | 1: combinational almost flags, 0: registered |
| dout | output | 18 | Read data or threshold readback; high impedance when disabled |
| empty_n | output | 1 | Low when empty (read clock) |
| full_n | output | 1 | Low when full (write clock) |
| half_n | output | 1 | Low when more than half full (write clock) |
| aempty_n | output | 1 | Low when at or below the almost-empty threshold |
| afull_n | output | 1 | Low when free space is at or below the almost-full threshold |

## Verification
The properties assume that `replay` is used only while the writes since reset have not exceeded DEPTH. Otherwise rewinding to zero would make the pointer difference meaningless and break the count bound. They also assume that `ld_n` changes only while both ports are idle, and that the thresholds are reprogrammed only while the read side is not using them. The stimulus respects these assumptions. It resets before the replay scenario and writes only ten words ahead of the replay. It switches `ld_n` and `async_mode` only between idle, settled phases. The random traffic phase keeps `ld_n` high and `replay` low throughout.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  localparam int PF_DATA_W = 18;

  typedef enum logic {
    OFS_EMPTY_SIDE = 1'b0,
    OFS_FULL_SIDE  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/pfifo_rst_sync.sv
module pfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/pfifo_ptr_sync.sv
module pfifo_ptr_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  // Gray to binary: each bit is the parity of all bits at or above it.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      bin_out[i] = ^(sync_q >> i);
    end
  end
endmodule

// File: rtl/pfifo_mem.sv
module pfifo_mem #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int NWORDS = 1 << AW;

  logic [DW-1:0] store [NWORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/pfifo_dual_clock.sv
module pfifo_dual_clock
  import pfifo_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DW      = PF_DATA_W,
  parameter int OFS_RST = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          ld_n,
  input  logic          replay,
  input  logic          oe_n,
  input  logic          async_mode,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n,
  output logic          aempty_n,
  output logic          afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [PW-1:0] OFS_R_P = PW'(OFS_RST);

  // ---------------- resets ----------------
  logic wrst_n, rrst_n;

  pfifo_rst_sync u_wrst (.clk(wr_clk), .rst_n(rst_n), .rst_n_sync(wrst_n));
  pfifo_rst_sync u_rrst (.clk(rd_clk), .rst_n(rst_n), .rst_n_sync(rrst_n));

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_ws, wcnt_d;
  logic [PW-1:0] ae_ofs_q, ae_ofs_d, af_ofs_q, af_ofs_d;
  ofs_sel_e      wsel_q, wsel_d;
  logic          full_q, full_d, half_q, half_d, afull_s_q, afull_s_d;
  logic          push, wload;

  assign push  = !wr_n && ld_n && !full_q;
  assign wload = !wr_n && !ld_n;

  always_comb begin
    wbin_d   = wbin_q + PW'(push);
    wgray_d  = wbin_d ^ (wbin_d >> 1);
    ae_ofs_d = ae_ofs_q;
    af_ofs_d = af_ofs_q;
    wsel_d   = wsel_q;
    if (wload) begin
      if (wsel_q == OFS_EMPTY_SIDE) begin
        ae_ofs_d = din[PW-1:0];
        wsel_d   = OFS_FULL_SIDE;
      end else begin
        af_ofs_d = din[PW-1:0];
        wsel_d   = OFS_EMPTY_SIDE;
      end
    end
    wcnt_d    = wbin_d - rbin_ws;
    full_d    = (wcnt_d == DEPTH_P);
    half_d    = (wcnt_d > HALF_P);
    afull_s_d = ((DEPTH_P - wcnt_d) <= af_ofs_d);
  end

  always_ff @(posedge wr_clk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q    <= '0;
      wgray_q   <= '0;
      ae_ofs_q  <= OFS_R_P;
      af_ofs_q  <= OFS_R_P;
      wsel_q    <= OFS_EMPTY_SIDE;
      full_q    <= 1'b0;
      half_q    <= 1'b0;
      afull_s_q <= 1'b0;
    end else begin
      wbin_q    <= wbin_d;
      wgray_q   <= wgray_d;
      ae_ofs_q  <= ae_ofs_d;
      af_ofs_q  <= af_ofs_d;
      wsel_q    <= wsel_d;
      full_q    <= full_d;
      half_q    <= half_d;
      afull_s_q <= afull_s_d;
    end
  end

  // ---------------- storage ----------------
  logic [PW-1:0] rbin_q;
  logic [DW-1:0] mem_rdata;

  pfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (wr_clk),
    .we    (push),
    .waddr (wbin_q[AW-1:0]),
    .wdata (din),
    .raddr (rbin_q[AW-1:0]),
    .rdata (mem_rdata)
  );

  // ---------------- pointer crossings ----------------
  logic [PW-1:0] rgray_q, rgray_d, wbin_rs;

  pfifo_ptr_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .gray_in(rgray_q), .bin_out(rbin_ws)
  );
  pfifo_ptr_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .gray_in(wgray_q), .bin_out(wbin_rs)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin_d, rcnt_d;
  logic [DW-1:0] q_q, q_d;
  ofs_sel_e      rsel_q, rsel_d;
  logic          empty_q, empty_d, aempty_s_q, aempty_s_d;
  logic          pop, rload;

  assign pop   = !rd_n && ld_n && !empty_q && !replay;
  assign rload = !rd_n && !ld_n;

  always_comb begin
    rbin_d = replay ? '0 : rbin_q + PW'(pop);
    rgray_d = rbin_d ^ (rbin_d >> 1);
    q_d    = q_q;
    rsel_d = rsel_q;
    if (rload) begin
      q_d    = (rsel_q == OFS_EMPTY_SIDE) ? DW'(ae_ofs_q) : DW'(af_ofs_q);
      rsel_d = (rsel_q == OFS_EMPTY_SIDE) ? OFS_FULL_SIDE : OFS_EMPTY_SIDE;
    end else if (pop) begin
      q_d = mem_rdata;
    end
    rcnt_d     = wbin_rs - rbin_d;
    empty_d    = (rcnt_d == '0);
    aempty_s_d = (rcnt_d <= ae_ofs_q);
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      q_q        <= '0;
      rsel_q     <= OFS_EMPTY_SIDE;
      empty_q    <= 1'b1;
      aempty_s_q <= 1'b1;
    end else begin
      rbin_q     <= rbin_d;
      rgray_q    <= rgray_d;
      q_q        <= q_d;
      rsel_q     <= rsel_d;
      empty_q    <= empty_d;
      aempty_s_q <= aempty_s_d;
    end
  end

  // ---------------- combinational almost flags ----------------
  logic [PW-1:0] live_cnt;
  logic          aempty_a, afull_a;

  always_comb begin
    live_cnt = wbin_q - rbin_q;
    aempty_a = (live_cnt <= ae_ofs_q);
    afull_a  = ((DEPTH_P - live_cnt) <= af_ofs_q);
  end

  // ---------------- outputs ----------------
  assign empty_n  = !empty_q;
  assign full_n   = !full_q;
  assign half_n   = !half_q;
  assign aempty_n = !(async_mode ? aempty_a : aempty_s_q);
  assign afull_n  = !(async_mode ? afull_a : afull_s_q);
  assign dout     = oe_n ? {DW{1'bz}} : q_q;
endmodule

// File: rtl/pfifo_dual_clock_chk.sv
module pfifo_dual_clock_chk #(
  parameter int PW    = 7,
  parameter int DEPTH = 64
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          ld_n,
  input logic          replay,
  input logic          full_q,
  input logic          empty_q,
  input logic [PW-1:0] wbin_q,
  input logic [PW-1:0] rbin_q,
  input logic [PW-1:0] rbin_ws,
  input logic [PW-1:0] wgray_q
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  assert_full_blocks_write_R2: assert property (
    @(posedge wr_clk) disable iff (!wrst_n)
    (full_q && !wr_n) |=> $stable(wbin_q));

  assert_empty_blocks_read_R3: assert property (
    @(posedge rd_clk) disable iff (!rrst_n)
    (empty_q && !rd_n && !replay) |=> $stable(rbin_q));

  assert_no_overflow_R4: assert property (
    @(posedge wr_clk) disable iff (!wrst_n)
    ((wbin_q - rbin_ws) <= DEPTH_P));

  assert_load_no_push_R5: assert property (
    @(posedge wr_clk) disable iff (!wrst_n)
    (!ld_n && !wr_n) |=> $stable(wbin_q));

  assert_load_no_pop_R6: assert property (
    @(posedge rd_clk) disable iff (!rrst_n)
    (!ld_n && !rd_n && !replay) |=> $stable(rbin_q));

  assert_replay_rewinds_R10: assert property (
    @(posedge rd_clk) disable iff (!rrst_n)
    replay |=> (rbin_q == '0));

  assert_gray_one_bit_R13: assert property (
    @(posedge wr_clk) disable iff (!wrst_n)
    ($countones(wgray_q ^ $past(wgray_q)) <= 1));
endmodule

bind pfifo_dual_clock pfifo_dual_clock_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (
  .wr_clk  (wr_clk),
  .rd_clk  (rd_clk),
  .wrst_n  (wrst_n),
  .rrst_n  (rrst_n),
  .wr_n    (wr_n),
  .rd_n    (rd_n),
  .ld_n    (ld_n),
  .replay  (replay),
  .full_q  (full_q),
  .empty_q (empty_q),
  .wbin_q  (wbin_q),
  .rbin_q  (rbin_q),
  .rbin_ws (rbin_ws),
  .wgray_q (wgray_q)
);

// File: tb/pfifo_dual_clock_test.sv
module pfifo_dual_clock_test;
  localparam int DEPTH = 64;

  logic        wclk = 1'b0, rclk = 1'b0;
  logic        rst_n, wr_n, rd_n, ld_n, replay, oe_n, async_mode;
  logic [17:0] din;
  wire  [17:0] dout;
  wire         empty_n, full_n, half_n, aempty_n, afull_n;

  pfifo_dual_clock uut (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .din(din), .wr_n(wr_n),
    .rd_n(rd_n), .ld_n(ld_n), .replay(replay), .oe_n(oe_n),
    .async_mode(async_mode), .dout(dout), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  always #10 wclk = ~wclk;   // 50 MHz write clock
  always #13 rclk = ~rclk;   // unrelated read clock

  int          n_chk = 0, n_bad = 0;
  bit          done = 0;
  logic [17:0] mq[$];
  logic [17:0] hist[$];
  int          ae_m, af_m;
  bit          wsel_m, rsel_m;
  bit          pend;
  logic [17:0] pexp, last_q;
  string       ptag;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic w_step(input bit en, input logic [17:0] d);
    @(negedge wclk);
    wr_n = !en;
    din  = d;
    if (en && !ld_n) begin
      if (!wsel_m) ae_m = int'(d[6:0]); else af_m = int'(d[6:0]);
      wsel_m = !wsel_m;
    end else if (en && full_n) begin
      mq.push_back(d);
      hist.push_back(d);
    end
  endtask

  task automatic r_step(input bit en, input string tag);
    @(negedge rclk);
    if (pend) begin
      check(ptag, 32'(dout), 32'(pexp));
      last_q = pexp;
      pend   = 0;
    end
    rd_n = !en;
    if (en && !ld_n) begin
      pexp   = rsel_m ? 18'(af_m) : 18'(ae_m);
      rsel_m = !rsel_m;
      pend   = 1;
      ptag   = tag;
    end else if (en && empty_n && !replay) begin
      pexp = mq.pop_front();
      pend = 1;
      ptag = tag;
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge wclk);
    @(negedge rclk);
  endtask

  task automatic check_flags(input string tag);
    int c;
    c = mq.size();
    check({tag, " empty_n"},  32'(empty_n),  32'(c != 0));
    check({tag, " full_n"},   32'(full_n),   32'(c != DEPTH));
    check({tag, " half_n"},   32'(half_n),   32'(!(c > DEPTH / 2)));
    check({tag, " aempty_n"}, 32'(aempty_n), 32'(!(c <= ae_m)));
    check({tag, " afull_n"},  32'(afull_n),  32'(!((DEPTH - c) <= af_m)));
  endtask

  task automatic do_reset();
    rst_n = 0; wr_n = 1; rd_n = 1; ld_n = 1; replay = 0; din = '0;
    mq.delete(); hist.delete();
    ae_m = 7; af_m = 7; wsel_m = 0; rsel_m = 0; pend = 0; last_q = '0;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    settle();
  endtask

  task automatic fill_to(input int n);
    while (mq.size() < n) w_step(1, 18'($urandom) | 18'h1);
    w_step(0, '0);
    settle();
  endtask

  task automatic drain(input string tag);
    while (mq.size() > 0) r_step(1, tag);
    r_step(0, tag);
    r_step(0, tag);
  endtask

  task automatic rand_writer(input int steps);
    for (int i = 0; i < steps; i++) begin
      int p;
      p = (i < steps / 2) ? 70 : 35;
      w_step(($urandom % 100) < p, 18'($urandom));
    end
    w_step(0, '0);
  endtask

  task automatic rand_reader(input int steps);
    for (int i = 0; i < steps; i++) begin
      int p;
      p = (i < steps / 2) ? 40 : 80;
      r_step(($urandom % 100) < p, "R1/R3 random");
    end
    r_step(0, "R3 random");
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = int'($urandom(32'd4242));
    oe_n = 0; async_mode = 0;
    do_reset();

    // R12: reset state
    check("R12 dout", 32'(dout), 32'h0);
    check_flags("R12");

    // R12/R6: default thresholds read back
    ld_n = 0;
    r_step(1, "R12 ae default");
    r_step(1, "R12 af default");
    r_step(0, "R6");

    // R5: load thresholds, no word stored
    w_step(1, 18'h3_0003);
    w_step(1, 18'h2_0005);
    w_step(0, '0);
    settle();
    check("R5 nothing stored empty_n", 32'(empty_n), 32'h0);

    // R6: alternating readback, no pop
    r_step(1, "R6 ae readback");
    r_step(1, "R6 af readback");
    r_step(1, "R6 ae again");
    r_step(0, "R6");
    r_step(0, "R6");
    ld_n = 1;
    settle();

    // R7: almost-empty boundary (threshold 3)
    fill_to(3);  check_flags("R7 count3");
    fill_to(4);  check_flags("R7 count4");
    // R9: half-full boundary
    fill_to(32); check_flags("R9 count32");
    fill_to(33); check_flags("R9 count33");
    // R7: almost-full boundary (threshold 5)
    fill_to(58); check_flags("R7 count58");
    fill_to(59); check_flags("R7 count59");
    // R4: full
    fill_to(64); check_flags("R4 full");
    // R2: writes while full are dropped
    w_step(1, 18'h1_2345);
    w_step(1, 18'h2_3456);
    w_step(0, '0);
    settle();
    check_flags("R2 after overflow attempt");
    // R1/R3: drain, order checked per word
    drain("R1/R3 order");
    settle();
    check_flags("R4 empty");
    // R3: read while empty leaves dout
    r_step(1, "R3");
    r_step(0, "R3");
    r_step(0, "R3");
    check("R3 underflow dout hold", 32'(dout), 32'(last_q));

    // R10: replay
    do_reset();
    fill_to(10);
    for (int i = 0; i < 4; i++) r_step(1, "R10 first pass");
    r_step(0, "R10");
    r_step(0, "R10");
    @(negedge rclk); replay = 1;
    @(negedge rclk); replay = 0;
    mq = hist;
    settle();
    check_flags("R10 count after replay");
    drain("R10 replayed data");
    settle();

    // R8: mode selection (ae threshold 7)
    fill_to(7);
    async_mode = 1;
    settle();
    check("R8 async at threshold", 32'(aempty_n), 32'h0);
    w_step(1, 18'h0_0abc);
    w_step(0, '0);
    check("R8 async immediate", 32'(aempty_n), 32'h1);
    r_step(1, "R8 pop");
    r_step(0, "R8");
    r_step(0, "R8");
    settle();
    check("R8 async back to threshold", 32'(aempty_n), 32'h0);
    async_mode = 0;
    settle();
    w_step(1, 18'h0_0def);
    w_step(0, '0);
    check("R8 sync lags", 32'(aempty_n), 32'h0);
    settle();
    check_flags("R7 sync settled");

    // R11: output enable
    oe_n = 1;
    #1;
    n_chk++;
    if (dout === last_q) begin
      n_bad++;
      $display("FAIL R11: actual %0h expected high impedance", dout);
    end
    oe_n = 0;
    #1;
    check("R11 driven", 32'(dout), 32'(last_q));
    drain("R3 cleanup");
    settle();

    // R1/R3/R4: random traffic
    fork
      rand_writer(700);
      rand_reader(700);
    join
    settle();
    check_flags("R4 after random");
    drain("R1/R3 random tail");
    settle();
    check_flags("R4 final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule